// File: doc/BRIEF.md
# Frame-Indexed Receive FIFO

This block buffers received frames for a host. A producer delivers already-decoded bytes one per cycle and flags the last byte of each frame; the block stores the bytes in a circular byte memory and records, for every completed frame, the address of its last byte in a small slot table. A write frame counter selects the slot being filled and advances on its own when a frame closes. A read frame counter selects the slot the host is working on. The host never writes this counter directly. It asks for the next frame with a release strobe once it has finished the current one.

The host sees the end address of the frame under its read frame counter, its own read byte pointer and the remaining length of that frame. It fetches bytes through a one-byte prefetch register. A select strobe loads that register from the read pointer, and every read strobe moves on to the next byte. The block also reports how many complete frames are held, a flag for a byte fill level above a programmable threshold, and a sticky overflow flag. A soft clear empties everything. The producer side has no backpressure, and a producer abort discards the frame that is still open.

Top module: `frame_rx_fifo`

## Requirements
- R1: After rst_n low or a one-cycle soft_clr pulse, frame_cnt is 0, empty is 1, rd_ptr is 0, ovf is 0 and rd_data is 0.
- R2: Every cycle with wr_en high and wr_abort low stores wr_data at the write address, which then increments modulo 128. There is no full condition and no input is ever refused.
- R3: A stored byte with wr_eof high closes the frame. In the next cycle the write frame counter has advanced by one modulo 8, frame_cnt has risen by one, and that frame's slot holds the address of the closing byte.
- R4: wr_abort moves the write address back to the first byte of the open frame and leaves the write frame counter unchanged. A byte presented in the same cycle is dropped, and later bytes overwrite the discarded ones.
- R5: While frame_cnt is nonzero, frm_end is the last-byte address of the frame under the read frame counter; otherwise frm_end equals rd_ptr. frm_len is (frm_end − rd_ptr) mod 128, plus one.
- R6: rd_stb with rd_ptr ≠ frm_end advances rd_ptr by one, and in the next cycle rd_data holds the byte at the new rd_ptr. With rd_ptr = frm_end, rd_stb changes nothing.
- R7: sel_stb loads rd_data with the byte at rd_ptr by the next cycle. rd_data is refreshed by nothing else, so after a release or a late write it can be stale until the next sel_stb.
- R8: rel_stb with frame_cnt > 0 advances the read frame counter by one modulo 8 and sets rd_ptr to the old frm_end plus one. With frame_cnt = 0, rel_stb has no effect.
- R9: empty is high exactly when frame_cnt = 0 and frm_end = rd_ptr.
- R10: fill_over is high when the held byte count, (write address − rd_ptr) mod 128, which includes the open frame, is strictly greater than thresh.
- R11: ovf is set when a frame closes while 7 frames are held, or when a byte is stored while 127 bytes are held. It stays set until reset or soft_clr.
- R12: soft_clr overrides every other input in its cycle. sel_stb overrides rd_stb and rel_stb in its cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| soft_clr | input | 1 | Empties the FIFO and clears the flags |
| wr_en | input | 1 | Producer byte valid |
| wr_data | input | 8 | Producer byte |
| wr_eof | input | 1 | Byte is the last of its frame |
| wr_abort | input | 1 | Discard the open frame |
| sel_stb | input | 1 | Reload the prefetch register from rd_ptr |
| rd_stb | input | 1 | Consume the prefetched byte |
| rel_stb | input | 1 | Release the current frame |
| thresh | input | 7 | Fill level threshold |
| rd_data | output | 8 | Prefetched byte |
| rd_ptr | output | 7 | Host read byte pointer |
| frm_end | output | 7 | Last-byte address of the current frame |
| frm_len | output | 8 | Bytes left in the current frame |
| frame_cnt | output | 3 | Complete frames held |
| empty | output | 1 | No frame held and nothing left to read |
| fill_over | output | 1 | Held bytes exceed thresh |
| ovf | output | 1 | Sticky overflow |

## Verification
The assertions assume that the strobes are single-cycle and that wr_eof and wr_abort arrive only with or beside a valid byte. They also assume that the host issues rel_stb only after reaching the frame end. They check that counters and pointers move only when the requirements allow it. The bench drives every input one cycle after a rising edge and returns it to idle after one cycle. It keeps the host within these rules, except in the directed cases that probe ignored and overridden strobes, where the assertions still hold.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int RXF_ADDR_W  = 7;
    localparam int RXF_FRAME_W = 3;
    localparam int RXF_DATA_W  = 8;

    typedef enum logic [1:0] {
        RD_IDLE,
        RD_LOAD,
        RD_STEP,
        RD_REL
    } rd_act_e;
endpackage

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int AW = rxf_pkg::RXF_ADDR_W,
    parameter int DW = rxf_pkg::RXF_DATA_W
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [DW-1:0] rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [DW-1:0] rdata_b
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata_a = mem_q[raddr_a];
    assign rdata_b = mem_q[raddr_b];
endmodule

// File: rtl/rxf_wr_side.sv
module rxf_wr_side #(
    parameter int AW = rxf_pkg::RXF_ADDR_W,
    parameter int FW = rxf_pkg::RXF_FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          wr_eof,
    input  logic          wr_abort,
    input  logic [FW-1:0] rd_frame,
    output logic [AW-1:0] wr_ptr,
    output logic [FW-1:0] wr_frame,
    output logic [AW-1:0] end_at_rd,
    output logic          we,
    output logic          close
);
    localparam int FRAMES = 1 << FW;

    typedef struct packed {
        logic [FRAMES-1:0][AW-1:0] tbl;
        logic [AW-1:0]             ptr;
        logic [AW-1:0]             start;
        logic [FW-1:0]             f1;
    } wr_state_t;

    wr_state_t st_d, st_q;

    always_comb begin
        st_d  = st_q;
        we    = wr_en && !wr_abort && !clr;
        close = we && wr_eof;
        if (wr_abort) begin
            st_d.ptr = st_q.start;
        end else if (wr_en) begin
            st_d.ptr = st_q.ptr + AW'(1);
            if (wr_eof) begin
                st_d.tbl[st_q.f1] = st_q.ptr;
                st_d.f1           = st_q.f1 + FW'(1);
                st_d.start        = st_q.ptr + AW'(1);
            end
        end
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr    = st_q.ptr;
    assign wr_frame  = st_q.f1;
    assign end_at_rd = st_q.tbl[rd_frame];

    AST_F1_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (close) |=> (st_q.f1 == $past(st_q.f1) + FW'(1))); // R3
    AST_ABORT_KEEPS_F1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !clr) |=> $stable(st_q.f1)); // R4
    AST_ABORT_REWINDS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_abort && !clr) |=> (st_q.ptr == $past(st_q.start))); // R4
endmodule

// File: rtl/rxf_rd_side.sv
module rxf_rd_side
    import rxf_pkg::*;
#(
    parameter int AW = rxf_pkg::RXF_ADDR_W,
    parameter int FW = rxf_pkg::RXF_FRAME_W,
    parameter int DW = rxf_pkg::RXF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          sel_stb,
    input  logic          rd_stb,
    input  logic          rel_stb,
    input  logic [FW-1:0] wr_frame,
    input  logic [AW-1:0] end_in,
    input  logic [DW-1:0] byte_cur,
    input  logic [DW-1:0] byte_nxt,
    output logic [AW-1:0] z2,
    output logic [FW-1:0] rd_frame,
    output logic [AW-1:0] z1,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [AW-1:0] z2;
        logic [FW-1:0] f2;
        logic [DW-1:0] buf_b;
    } rd_state_t;

    rd_state_t st_d, st_q;
    rd_act_e   act;
    logic      has_frame;

    always_comb begin
        has_frame = (wr_frame != st_q.f2);
        z1        = has_frame ? end_in : st_q.z2;
        if (sel_stb)                   act = RD_LOAD;
        else if (rel_stb && has_frame) act = RD_REL;
        else if (rd_stb && st_q.z2 != z1) act = RD_STEP;
        else                           act = RD_IDLE;

        st_d = st_q;
        unique case (act)
            RD_LOAD: st_d.buf_b = byte_cur;
            RD_REL: begin
                st_d.f2 = st_q.f2 + FW'(1);
                st_d.z2 = z1 + AW'(1);
            end
            RD_STEP: begin
                st_d.z2    = st_q.z2 + AW'(1);
                st_d.buf_b = byte_nxt;
            end
            default: ;
        endcase
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign z2       = st_q.z2;
    assign rd_frame = st_q.f2;
    assign rd_data  = st_q.buf_b;

    AST_STALL_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !sel_stb && !rel_stb && !clr && st_q.z2 == z1)
        |=> ($stable(st_q.z2) && $stable(st_q.buf_b))); // R6
    AST_REL_IGNORED_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_stb && !sel_stb && !clr && !has_frame)
        |=> ($stable(st_q.f2) && $stable(st_q.z2))); // R8
    AST_SEL_BLOCKS_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_stb && !clr) |=> ($stable(st_q.z2) && $stable(st_q.f2))); // R12
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
    parameter int AW = rxf_pkg::RXF_ADDR_W,
    parameter int FW = rxf_pkg::RXF_FRAME_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] z2,
    input  logic [FW-1:0] wr_frame,
    input  logic [FW-1:0] rd_frame,
    input  logic          byte_in,
    input  logic          frame_in,
    input  logic [AW-1:0] thresh,
    output logic [FW-1:0] frame_cnt,
    output logic          fill_over,
    output logic          ovf
);
    logic [AW-1:0] held;
    logic          ovf_d, ovf_q;

    always_comb begin
        held      = wr_ptr - z2;
        frame_cnt = wr_frame - rd_frame;
        fill_over = (held > thresh);
        ovf_d     = ovf_q
                  | (frame_in && frame_cnt == {FW{1'b1}})
                  | (byte_in && held == {AW{1'b1}});
        if (clr) ovf_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ovf_q <= 1'b0;
        else        ovf_q <= ovf_d;
    end

    assign ovf = ovf_q;

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !clr) |=> ovf_q); // R11
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_q && !byte_in) |=> !ovf_q); // R11
endmodule

// File: rtl/frame_rx_fifo.sv
module frame_rx_fifo #(
    parameter int AW = rxf_pkg::RXF_ADDR_W,
    parameter int FW = rxf_pkg::RXF_FRAME_W,
    parameter int DW = rxf_pkg::RXF_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_clr,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_eof,
    input  logic          wr_abort,
    input  logic          sel_stb,
    input  logic          rd_stb,
    input  logic          rel_stb,
    input  logic [AW-1:0] thresh,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_ptr,
    output logic [AW-1:0] frm_end,
    output logic [AW:0]   frm_len,
    output logic [FW-1:0] frame_cnt,
    output logic          empty,
    output logic          fill_over,
    output logic          ovf
);
    logic [AW-1:0] wr_ptr, end_at_rd, z2, z1;
    logic [FW-1:0] wr_frame, rd_frame;
    logic          we, close;
    logic [DW-1:0] byte_cur, byte_nxt;

    rxf_wr_side #(.AW(AW), .FW(FW)) u_wr (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .wr_en(wr_en), .wr_eof(wr_eof), .wr_abort(wr_abort),
        .rd_frame(rd_frame), .wr_ptr(wr_ptr), .wr_frame(wr_frame),
        .end_at_rd(end_at_rd), .we(we), .close(close)
    );

    rxf_store #(.AW(AW), .DW(DW)) u_mem (
        .clk(clk), .we(we), .waddr(wr_ptr), .wdata(wr_data),
        .raddr_a(z2), .rdata_a(byte_cur),
        .raddr_b(z2 + AW'(1)), .rdata_b(byte_nxt)
    );

    rxf_rd_side #(.AW(AW), .FW(FW), .DW(DW)) u_rd (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .sel_stb(sel_stb), .rd_stb(rd_stb), .rel_stb(rel_stb),
        .wr_frame(wr_frame), .end_in(end_at_rd),
        .byte_cur(byte_cur), .byte_nxt(byte_nxt),
        .z2(z2), .rd_frame(rd_frame), .z1(z1), .rd_data(rd_data)
    );

    rxf_level #(.AW(AW), .FW(FW)) u_lvl (
        .clk(clk), .rst_n(rst_n), .clr(soft_clr),
        .wr_ptr(wr_ptr), .z2(z2), .wr_frame(wr_frame), .rd_frame(rd_frame),
        .byte_in(we), .frame_in(close), .thresh(thresh),
        .frame_cnt(frame_cnt), .fill_over(fill_over), .ovf(ovf)
    );

    assign rd_ptr  = z2;
    assign frm_end = z1;
    assign frm_len = {1'b0, z1 - z2} + (AW+1)'(1);
    assign empty   = (frame_cnt == '0) && (z1 == z2);

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        soft_clr |=> (empty && !ovf && rd_ptr == '0)); // R1
    AST_EMPTY_NO_FRAMES: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && !wr_en) |=> (frame_cnt == '0)); // R9
endmodule

// File: tb/sim_frame_rx_fifo.sv
module sim_frame_rx_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_clr = 0, wr_en = 0, wr_eof = 0, wr_abort = 0;
    logic       sel_stb = 0, rd_stb = 0, rel_stb = 0;
    logic [7:0] wr_data = 0;
    logic [6:0] thresh = 0;
    logic [7:0] rd_data;
    logic [6:0] rd_ptr, frm_end;
    logic [7:0] frm_len;
    logic [2:0] frame_cnt;
    logic       empty, fill_over, ovf;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    frame_rx_fifo u0 (
        .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
        .wr_en(wr_en), .wr_data(wr_data), .wr_eof(wr_eof), .wr_abort(wr_abort),
        .sel_stb(sel_stb), .rd_stb(rd_stb), .rel_stb(rel_stb), .thresh(thresh),
        .rd_data(rd_data), .rd_ptr(rd_ptr), .frm_end(frm_end), .frm_len(frm_len),
        .frame_cnt(frame_cnt), .empty(empty), .fill_over(fill_over), .ovf(ovf)
    );

    // op codes: 0 byte, 1 byte closing frame, 2 select, 3 check then read,
    // 4 release, 5 check frame count
    localparam int NV = 17;
    localparam logic [10:0] VEC [NV] = '{
        {3'd0, 8'h11}, {3'd0, 8'h22}, {3'd1, 8'h33}, {3'd5, 8'd1},
        {3'd0, 8'h44}, {3'd1, 8'h55}, {3'd5, 8'd2}, {3'd2, 8'h00},
        {3'd3, 8'h11}, {3'd3, 8'h22}, {3'd3, 8'h33}, {3'd4, 8'h00},
        {3'd5, 8'd1},  {3'd2, 8'h00}, {3'd3, 8'h44}, {3'd3, 8'h55},
        {3'd4, 8'h00}
    };

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        soft_clr = 0; wr_en = 0; wr_eof = 0; wr_abort = 0;
        sel_stb = 0; rd_stb = 0; rel_stb = 0;
    endtask

    task automatic put(input logic [7:0] d, input logic eof);
        wr_en = 1; wr_data = d; wr_eof = eof;
        cyc();
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 cnt", frame_cnt, 0);
        chk("R1 empty", empty, 1);
        chk("R1 rd_ptr", rd_ptr, 0);
        chk("R1 ovf", ovf, 0);
        chk("R5 len at rest", frm_len, 1);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][10:8])
                3'd0: put(VEC[i][7:0], 0);
                3'd1: put(VEC[i][7:0], 1);
                3'd2: begin sel_stb = 1; cyc(); end
                3'd3: begin
                    chk("R6 R7 table byte", rd_data, VEC[i][7:0]);
                    rd_stb = 1; cyc();
                end
                3'd4: begin rel_stb = 1; cyc(); end
                default: chk("R3 table frame count", frame_cnt, VEC[i][7:0]);
            endcase
        end
        chk("R8 table cnt", frame_cnt, 0);
        chk("R9 table empty", empty, 1);
        chk("R8 table rd_ptr", rd_ptr, 5);

        // R2 R5 R10 a four-byte frame at 5..8
        put(8'hA0, 0); put(8'hA1, 0); put(8'hA2, 0); put(8'hA3, 1);
        chk("R5 frm_end", frm_end, 8);
        chk("R5 frm_len", frm_len, 4);
        chk("R2 R3 cnt", frame_cnt, 1);
        chk("R9 not empty", empty, 0);
        thresh = 3; #1;
        chk("R10 fill above", fill_over, 1);
        thresh = 4; #1;
        chk("R10 fill equal", fill_over, 0);
        sel_stb = 1; cyc();
        chk("R7 sel load", rd_data, 8'hA0);
        rd_stb = 1; cyc();
        chk("R6 step data", rd_data, 8'hA1);
        chk("R6 step ptr", rd_ptr, 6);
        chk("R5 len shrinks", frm_len, 3);
        rd_stb = 1; cyc(); rd_stb = 1; cyc();
        rd_stb = 1; cyc();
        chk("R6 stall ptr", rd_ptr, 8);
        chk("R6 stall data", rd_data, 8'hA3);
        rel_stb = 1; cyc();
        chk("R8 release ptr", rd_ptr, 9);
        rel_stb = 1; cyc();
        chk("R8 idle release ptr", rd_ptr, 9);
        chk("R8 idle release cnt", frame_cnt, 0);

        // R4 abort, including a byte in the abort cycle
        put(8'hAA, 0); put(8'hBB, 0);
        wr_en = 1; wr_data = 8'hEE; wr_abort = 1; cyc();
        chk("R4 cnt kept", frame_cnt, 0);
        put(8'hCC, 1);
        chk("R4 end", frm_end, 9);
        chk("R4 len", frm_len, 1);
        sel_stb = 1; cyc();
        chk("R4 overwrite", rd_data, 8'hCC);
        rd_stb = 1; cyc();
        rel_stb = 1; cyc();
        put(8'hDD, 1);
        chk("R7 stale", rd_data, 8'hCC);
        sel_stb = 1; cyc();
        chk("R7 reload", rd_data, 8'hDD);

        // R1 soft clear
        soft_clr = 1; cyc();
        chk("R1 clr cnt", frame_cnt, 0);
        chk("R1 clr ptr", rd_ptr, 0);
        chk("R1 clr empty", empty, 1);
        chk("R1 clr data", rd_data, 0);

        // R11 frame overflow
        for (int k = 0; k < 7; k++) put(8'(k), 1);
        chk("R3 seven frames", frame_cnt, 7);
        chk("R11 no ovf yet", ovf, 0);
        put(8'h77, 1);
        chk("R3 wrap cnt", frame_cnt, 0);
        chk("R11 frame ovf", ovf, 1);
        put(8'h78, 0);
        chk("R11 sticky", ovf, 1);
        soft_clr = 1; cyc();
        chk("R1 clr ovf", ovf, 0);

        // R2 R11 byte overflow
        for (int k = 0; k < 127; k++) put(8'(k), 0);
        thresh = 126; #1;
        chk("R2 all accepted", fill_over, 1);
        chk("R11 127 held", ovf, 0);
        put(8'hF0, 0);
        chk("R11 byte ovf", ovf, 1);
        soft_clr = 1; cyc();

        // R12 priorities
        soft_clr = 1; wr_en = 1; wr_eof = 1; wr_data = 8'h99; cyc();
        thresh = 0; #1;
        chk("R12 clr beats write cnt", frame_cnt, 0);
        chk("R12 clr beats write fill", fill_over, 0);
        put(8'h31, 0); put(8'h32, 1);
        sel_stb = 1; cyc();
        sel_stb = 1; rd_stb = 1; cyc();
        chk("R12 sel beats read ptr", rd_ptr, 0);
        chk("R12 sel beats read data", rd_data, 8'h31);
        sel_stb = 1; rel_stb = 1; cyc();
        chk("R12 sel beats release", frame_cnt, 1);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule